// File: doc/BRIEF.md
# Musical Note Waveform Synthesizer

This block is a single-voice tone generator for the audio range, built on direct digital synthesis. A 4-bit note code picks one of the twelve semitones of an equal-tempered octave, and a 2-bit code picks one of four waveform shapes. Each note has a fixed phase increment. A 32-bit phase accumulator adds that increment on every clock while the block is enabled. The ten most significant phase bits address one period of 1024 points, and the shape stage turns that address into a 9-bit sample.

The sample then drives a pulse-width modulator with a 9-bit carrier. Its one-bit output is meant to feed an external analog low-pass filter. The raw sample is also brought out so that it can be observed during test.

All outputs run freely and are never stalled. There is no data handshake: the sample and the PWM bit change on fixed clock edges, and the block cannot apply back-pressure. The selection inputs are plain levels, and the block samples them on every clock.

Top module: `tone_synth`

## Requirements
- R1: While `rst` is high, `sample_o` is 0 and `pwm_o` is 1, because the carrier counter is 0 and the latched duty is 256.
- R2: The phase is 32 bits wide and wraps modulo 2^32. On every enabled clock it grows by round(f × 2^32 / CLK_HZ). The frequency f is taken from `note_sel` in millihertz: 0=261626, 1=277183, 2=293665, 3=311127, 4=329628, 5=349228, 6=369994, 7=391995, 8=415305, 9=440000, 10=466164, 11=493883. Codes 12 to 15 give an increment of 0. `sample_o` is the shape value of phase bits [31:22] as they stood one clock earlier.
- R3: With `wave_sel`=0 (sine), the sample is round(256 + 255·sin(2π·a/1024)) for address a.
- R4: With `wave_sel`=1 (square), the sample is 511 for a < 512 and 0 otherwise.
- R5: With `wave_sel`=2 (sawtooth), the sample is a >> 1.
- R6: With `wave_sel`=3 (triangle), the sample is a for a < 512 and 1023 − a otherwise.
- R7: A 9-bit carrier counter runs freely from 0 to 511. `pwm_o` is high while the counter is below the latched duty. The duty is loaded only in the clock where the counter is 511, so each new value starts at count 0.
- R8: While `en` is low, the phase holds, so `sample_o` stays constant. Each duty load in that time takes 256, which gives 256 high cycles in every 512.
- R9: A change of `note_sel` or `wave_sel` takes effect at the next clock and leaves the phase as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the phase and idles the PWM at half duty |
| note_sel | input | 4 | Semitone code, 0 to 11 |
| wave_sel | input | 2 | Shape: 0 sine, 1 square, 2 sawtooth, 3 triangle |
| pwm_o | output | 1 | Pulse-width-modulated audio bit |
| sample_o | output | 9 | Current 9-bit sample, for test |

## Verification
The bench plays all four shapes at both ends of the octave and compares every clock against its model.

It switches note and shape in mid-period. A design that reset the phase on a selection change would jump back to the start of the table there.

It holds `en` low long enough to cover a full carrier period. A design that latched the duty outside the counter wrap would show a duty other than 256 in that time, and a design that kept the accumulator running would show a changing sample.

It also drives the unused note codes, where the phase must freeze. A design that took the increment from the wrong table entry would drift away from the model sample by sample.

// File: rtl/nsyn_pkg.sv
package nsyn_pkg;

  typedef enum logic [1:0] {
    WV_SINE   = 2'd0,
    WV_SQUARE = 2'd1,
    WV_SAW    = 2'd2,
    WV_TRI    = 2'd3
  } wave_e;

  // Note frequency in millihertz; codes outside the octave give 0.
  function automatic longint unsigned note_mhz(input int n);
    case (n)
      0:  return 64'd261626;
      1:  return 64'd277183;
      2:  return 64'd293665;
      3:  return 64'd311127;
      4:  return 64'd329628;
      5:  return 64'd349228;
      6:  return 64'd369994;
      7:  return 64'd391995;
      8:  return 64'd415305;
      9:  return 64'd440000;
      10: return 64'd466164;
      11: return 64'd493883;
      default: return 64'd0;
    endcase
  endfunction

  // Rounded phase step: f * 2^pw / clk
  function automatic longint unsigned tune_word(input int n, input longint unsigned clk_hz,
                                                input int pw);
    longint unsigned num;
    longint unsigned den;
    den = clk_hz * 64'd1000;
    num = (note_mhz(n) << pw) + (den >> 1);
    return num / den;
  endfunction

endpackage

// File: rtl/nsyn_phase.sv
module nsyn_phase #(
  parameter int          PHASE_W   = 32,
  parameter int          ADDR_W    = 10,
  parameter int          NOTE_W    = 4,
  parameter int          NUM_NOTES = 12,
  parameter int unsigned CLK_HZ    = 250_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [NOTE_W-1:0] note,
  output logic [ADDR_W-1:0] addr
);
  import nsyn_pkg::*;

  localparam int NUM_CODES = 2 ** NOTE_W;

  logic [PHASE_W-1:0] tune_tab [NUM_CODES];
  logic [PHASE_W-1:0] phase_q;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tune
    if (g < NUM_NOTES) begin : g_note
      assign tune_tab[g] = PHASE_W'(tune_word(g, 64'(CLK_HZ), PHASE_W));
    end else begin : g_none
      assign tune_tab[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     phase_q <= '0;
    else if (en) phase_q <= phase_q + tune_tab[note];
  end

  assign addr = phase_q[PHASE_W-1 -: ADDR_W];

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase_q));
  p_null_note_r2: assert property (@(posedge clk) disable iff (rst)
    (en && int'(note) >= NUM_NOTES) |=> $stable(phase_q));
  p_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (en && int'(note) < NUM_NOTES) |=> !$stable(phase_q));

endmodule

// File: rtl/nsyn_shape.sv
module nsyn_shape #(
  parameter int SAMPLE_W = 9,
  parameter int ADDR_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  nsyn_pkg::wave_e     wave,
  input  logic [ADDR_W-1:0]   addr,
  output logic [SAMPLE_W-1:0] sample_q
);
  import nsyn_pkg::*;

  localparam int DEPTH = 2 ** ADDR_W;
  localparam logic [SAMPLE_W-1:0] FULL = '1;
  localparam real MID_R = real'(2 ** (SAMPLE_W - 1));
  localparam real AMP_R = MID_R - 1.0;

  logic [SAMPLE_W-1:0] sine_rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      sine_rom[i] = SAMPLE_W'($rtoi(MID_R + AMP_R *
                    $sin(2.0 * 3.141592653589793 * real'(i) / real'(DEPTH)) + 0.5));
    end
  end

  logic                upper;
  logic [SAMPLE_W-1:0] low_bits;
  assign upper    = addr[ADDR_W-1];
  assign low_bits = addr[SAMPLE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) sample_q <= '0;
    else begin
      case (wave)
        WV_SINE:   sample_q <= sine_rom[addr];
        WV_SQUARE: sample_q <= upper ? '0 : FULL;
        WV_SAW:    sample_q <= addr[ADDR_W-1:1];
        default:   sample_q <= upper ? ~low_bits : low_bits;
      endcase
    end
  end

  p_square_lvl_r4: assert property (@(posedge clk) disable iff (rst)
    (wave == WV_SQUARE) |=> (sample_q == '0 || sample_q == FULL));
  p_sine_floor_r3: assert property (@(posedge clk) disable iff (rst)
    (wave == WV_SINE) |=> (sample_q != '0));

endmodule

// File: rtl/nsyn_pwm.sv
module nsyn_pwm #(
  parameter int SAMPLE_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                pwm
);
  localparam logic [SAMPLE_W-1:0] TOP = '1;
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(2 ** (SAMPLE_W - 1));

  logic [SAMPLE_W-1:0] cnt_q;
  logic [SAMPLE_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= MID;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == TOP) duty_q <= en ? sample : MID;
    end
  end

  assign pwm = (cnt_q < duty_q);

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP) |=> (cnt_q == '0));
  p_duty_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != TOP) |=> $stable(duty_q));
  p_idle_half_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == TOP && !en) |=> (duty_q == MID));

endmodule

// File: rtl/tone_synth.sv
module tone_synth #(
  parameter int          PHASE_W   = 32,
  parameter int          SAMPLE_W  = 9,
  parameter int          NOTE_W    = 4,
  parameter int          NUM_NOTES = 12,
  parameter int unsigned CLK_HZ    = 250_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [NOTE_W-1:0]   note_sel,
  input  logic [1:0]          wave_sel,
  output logic                pwm_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  import nsyn_pkg::*;

  localparam int ADDR_W = SAMPLE_W + 1;

  logic [ADDR_W-1:0] addr;
  wave_e             wave;
  assign wave = wave_e'(wave_sel);

  nsyn_phase #(
    .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .NOTE_W(NOTE_W),
    .NUM_NOTES(NUM_NOTES), .CLK_HZ(CLK_HZ)
  ) phase_i (
    .clk(clk), .rst(rst), .en(en), .note(note_sel), .addr(addr)
  );

  nsyn_shape #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) shape_i (
    .clk(clk), .rst(rst), .wave(wave), .addr(addr), .sample_q(sample_o)
  );

  nsyn_pwm #(.SAMPLE_W(SAMPLE_W)) pwm_i (
    .clk(clk), .rst(rst), .en(en), .sample(sample_o), .pwm(pwm_o)
  );

endmodule

// File: tb/tone_synth_tb_top.sv
`timescale 1ns/1ps
module tone_synth_tb_top;
  localparam longint CLK_HZ = 1_000_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [3:0] note_sel = 4'd9;
  logic [1:0] wave_sel = 2'd0;
  logic       pwm_o;
  logic [8:0] sample_o;

  int total = 0;
  int bad   = 0;
  bit started = 0;
  bit done    = 0;
  string seg_tag = "R2";

  always #2 clk = ~clk;

  tone_synth #(.CLK_HZ(32'(CLK_HZ))) dut_i (
    .clk(clk), .rst(rst), .en(en), .note_sel(note_sel), .wave_sel(wave_sel),
    .pwm_o(pwm_o), .sample_o(sample_o)
  );

  function automatic longint mhz_of(input int n);
    longint t[12] = '{261626, 277183, 293665, 311127, 329628, 349228,
                      369994, 391995, 415305, 440000, 466164, 493883};
    if (n > 11) return 0;
    return t[n];
  endfunction

  function automatic longint step_of(input int n);
    longint den = CLK_HZ * 1000;
    return (mhz_of(n) * 64'd4294967296 + den / 2) / den;
  endfunction

  function automatic int shape_of(input int w, input int a);
    case (w)
      0: return $rtoi(256.0 + 255.0 * $sin(2.0 * 3.141592653589793 * a / 1024.0) + 0.5);
      1: return (a < 512) ? 511 : 0;
      2: return a / 2;
      default: return (a < 512) ? a : 1023 - a;
    endcase
  endfunction

  function automatic string wave_tag(input int w);
    case (w)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural reference
  longint m_ph = 0;
  int m_smp = 0, m_cnt = 0, m_duty = 256, m_wave = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_ph = 0; m_smp = 0; m_cnt = 0; m_duty = 256;
    end else begin
      if (m_cnt == 511) m_duty = en ? m_smp : 256;
      m_cnt = (m_cnt + 1) % 512;
      m_smp = shape_of(wave_sel, int'(m_ph / 4194304));
      m_wave = wave_sel;
      if (en) m_ph = (m_ph + step_of(note_sel)) % 64'd4294967296;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check({wave_tag(m_wave), " sample ", seg_tag}, int'(sample_o), m_smp);
      check({"R7 pwm ", seg_tag}, int'(pwm_o), (m_cnt < m_duty) ? 1 : 0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int held;
    int highs;
    run(4);
    check("R1 reset sample", int'(sample_o), 0);
    check("R1 reset pwm", int'(pwm_o), 1);
    rst = 1'b0; en = 1'b1;
    seg_tag = "R2"; wave_sel = 2'd0; note_sel = 4'd9; run(3000);
    wave_sel = 2'd1; note_sel = 4'd0; run(2500);
    wave_sel = 2'd2; note_sel = 4'd11; run(2500);
    wave_sel = 2'd3; note_sel = 4'd5; run(2500);
    seg_tag = "R9";
    wave_sel = 2'd0; note_sel = 4'd2; run(777);
    note_sel = 4'd10; run(333);
    wave_sel = 2'd3; run(401);
    wave_sel = 2'd1; note_sel = 4'd7; run(555);
    seg_tag = "R8"; en = 1'b0;
    run(5);
    held = int'(sample_o);
    run(600);
    highs = 0;
    for (int i = 0; i < 512; i++) begin
      if (pwm_o) highs++;
      run(1);
    end
    check("R8 idle duty highs", highs, 256);
    check("R8 sample held", int'(sample_o), held);
    en = 1'b1; wave_sel = 2'd0; run(1500);
    seg_tag = "R2 null note"; note_sel = 4'd13; run(5);
    held = int'(sample_o);
    run(300);
    check("R2 null note holds", int'(sample_o), held);
    note_sel = 4'd3; wave_sel = 2'd2; run(2000);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule